// File: doc/BRIEF.md
# Floating-Point Exception Status Updater

This block folds the exception flags of a finished floating-point operation into the status word of the floating-point unit. It also decides whether the operation must trap. Each time the completion strobe is high, it samples three things: the five raw exception flags, the current status word and the program-counter pair. On the next clock edge it registers the updated status word, a one-cycle trap request and the program-counter pair that follows.

When no enabled flag is raised, the operation retires normally. The raw flags become the current-exception field and are also added to the accrued field. The program counter moves to the next-PC, and the next-PC steps forward by one instruction.

When at least one raised flag is also enabled, the block requests a trap and keeps the program counter where it is. Exactly one flag is reported, picked by fixed priority among the enabled ones. The accrued field is left as it was, and the trap-type field is marked as an IEEE exception. The arithmetic that produces the flags and the trap vectoring lie outside this block.

Top module: `fpx_status_upd`

## Requirements
- R1: While reset is asserted, and until the first strobe after release, the status output, the trap request and both program-counter outputs read zero.
- R2: One cycle after a strobe, the trap request is high exactly when the raw flags ANDed with the trap-enable field (status bits 27:23) are nonzero. Without a strobe it is low.
- R3: On a trap, the current-exception field (bits 4:0) holds a single set bit. That bit is the highest-priority set bit of the enabled flags, in the order invalid (bit 4), overflow (bit 3), underflow (bit 2), divide-by-zero (bit 1), inexact (bit 0).
- R4: Without a trap, the current-exception field equals the raw flags.
- R5: Without a trap, the accrued field (bits 9:5) becomes its input value ORed with the new current-exception field. On a trap, it keeps its input value.
- R6: On a trap, the trap-type field (bits 16:14) becomes 3'b001. Without a trap, it keeps its input value.
- R7: On a trap, the program-counter outputs repeat the sampled PC and next-PC. Without a trap, the PC output takes the sampled next-PC and the next-PC output takes the sampled next-PC plus 4.
- R8: An operation with all raw flags zero clears the current-exception field, requests no trap and advances the program counter.
- R9: In a cycle without a strobe, all outputs keep their values, whatever the other inputs do.
- R10: Status bits outside the current, accrued and trap-type fields, including the trap-enable field, pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_done | input | 1 | Completion strobe of a floating-point operation |
| op_flags | input | 5 | Raw exception flags of that operation |
| stat_in | input | 32 | Current status word |
| pc_in | input | 32 | Program counter of the operation |
| npc_in | input | 32 | Next program counter |
| stat_out | output | 32 | Updated status word |
| trap_req | output | 1 | One-cycle trap request |
| pc_out | output | 32 | Program counter after the operation |
| npc_out | output | 32 | Next program counter after the operation |

## Verification
The assertions assume that the status word, flags and program counters are stable and meaningful only in the cycle where the strobe is high. They also assume that the strobe is not compared against values from before the reset release. The stimulus drives every input at the falling edge and raises the strobe for exactly one cycle. It then follows with an idle cycle in which all other inputs are scrambled, so the hold behaviour is exercised under changing inputs. Every pairing of the 32 flag patterns with the 32 enable masks is swept, each on a fresh random background for the remaining status bits and the program counters.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int FLAG_W   = 5;
  localparam int CEXC_LSB = 0;
  localparam int AEXC_LSB = 5;
  localparam int FTT_LSB  = 14;
  localparam int FTT_W    = 3;
  localparam int TEM_LSB  = 23;
  localparam logic [FTT_W-1:0] FTT_IEEE = 3'd1;

  // Flag positions; a higher index wins when one flag must be chosen.
  typedef enum int {
    FX_INEXACT  = 0,
    FX_DIVZERO  = 1,
    FX_UNDERFL  = 2,
    FX_OVERFL   = 3,
    FX_INVALID  = 4
  } fx_bit_e;
endpackage

// File: rtl/fpx_prio_pick.sv
module fpx_prio_pick #(
  parameter int W = 5
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] pick
);
  always_comb begin
    pick = '0;
    for (int i = 0; i < W; i++) begin
      if (req[i]) pick = W'(1) << i;
    end
  end

  always_comb begin
    p_pick_onehot_r3: assert ($onehot0(pick));
    p_pick_subset_r3: assert ((pick & ~req) == '0);
  end
endmodule

// File: rtl/fpx_stat_merge.sv
module fpx_stat_merge
  import fpx_pkg::*;
#(
  parameter int STAT_W = 32
) (
  input  logic [STAT_W-1:0] stat_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              trap_o,
  output logic [STAT_W-1:0] stat_o
);
  logic [FLAG_W-1:0] enabled;
  logic [FLAG_W-1:0] one_flag;
  logic [FLAG_W-1:0] cexc;

  assign enabled = flags_i & stat_i[TEM_LSB +: FLAG_W];
  assign trap_o  = |enabled;

  fpx_prio_pick #(.W(FLAG_W)) u_pick (
    .req  (enabled),
    .pick (one_flag)
  );

  assign cexc = trap_o ? one_flag : flags_i;

  always_comb begin
    stat_o = stat_i;
    stat_o[CEXC_LSB +: FLAG_W] = cexc;
    if (trap_o) begin
      stat_o[FTT_LSB +: FTT_W] = FTT_IEEE;
    end else begin
      stat_o[AEXC_LSB +: FLAG_W] = stat_i[AEXC_LSB +: FLAG_W] | cexc;
    end
  end

  always_comb begin
    p_trap_cexc_single_r3: assert (!trap_o || $countones(stat_o[CEXC_LSB +: FLAG_W]) == 1);
    p_tem_passthru_r10: assert (stat_o[TEM_LSB +: FLAG_W] == stat_i[TEM_LSB +: FLAG_W]);
  end
endmodule

// File: rtl/fpx_pc_step.sv
module fpx_pc_step #(
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  logic            hold_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] npc_i,
  output logic [PC_W-1:0] pc_o,
  output logic [PC_W-1:0] npc_o
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  always_comb begin
    if (hold_i) begin
      pc_o  = pc_i;
      npc_o = npc_i;
    end else begin
      pc_o  = npc_i;
      npc_o = npc_i + STEP;
    end
  end
endmodule

// File: rtl/fpx_status_upd.sv
module fpx_status_upd
  import fpx_pkg::*;
#(
  parameter int STAT_W  = 32,
  parameter int PC_W    = 32,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_done,
  input  logic [FLAG_W-1:0] op_flags,
  input  logic [STAT_W-1:0] stat_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [PC_W-1:0]   npc_in,
  output logic [STAT_W-1:0] stat_out,
  output logic              trap_req,
  output logic [PC_W-1:0]   pc_out,
  output logic [PC_W-1:0]   npc_out
);
  logic [1:0]        rst_sync;
  logic              rst_ok_n;
  logic              trap_c;
  logic [STAT_W-1:0] stat_c;
  logic [PC_W-1:0]   pc_c, npc_c;

  logic [STAT_W-1:0] stat_q, stat_d;
  logic              trap_q, trap_d;
  logic [PC_W-1:0]   pc_q, pc_d, npc_q, npc_d;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok_n = rst_sync[1];

  fpx_stat_merge #(.STAT_W(STAT_W)) u_merge (
    .stat_i  (stat_in),
    .flags_i (op_flags),
    .trap_o  (trap_c),
    .stat_o  (stat_c)
  );

  fpx_pc_step #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_step (
    .hold_i (trap_c),
    .pc_i   (pc_in),
    .npc_i  (npc_in),
    .pc_o   (pc_c),
    .npc_o  (npc_c)
  );

  // next state
  always_comb begin
    stat_d = stat_q;
    pc_d   = pc_q;
    npc_d  = npc_q;
    trap_d = 1'b0;
    if (op_done) begin
      stat_d = stat_c;
      pc_d   = pc_c;
      npc_d  = npc_c;
      trap_d = trap_c;
    end
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      stat_q <= '0;
      trap_q <= 1'b0;
      pc_q   <= '0;
      npc_q  <= '0;
    end else begin
      stat_q <= stat_d;
      trap_q <= trap_d;
      pc_q   <= pc_d;
      npc_q  <= npc_d;
    end
  end

  assign stat_out = stat_q;
  assign trap_req = trap_q;
  assign pc_out   = pc_q;
  assign npc_out  = npc_q;

  p_trap_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !op_done |=> !trap_req);
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !op_done |=> ($stable(stat_out) && $stable(pc_out) && $stable(npc_out)));
  p_aexc_kept_on_trap_r5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    op_done |=> (!trap_req || stat_out[AEXC_LSB +: FLAG_W] == $past(stat_in[AEXC_LSB +: FLAG_W])));
  p_pc_hold_on_trap_r7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    op_done |=> (!trap_req || (pc_out == $past(pc_in) && npc_out == $past(npc_in))));
  p_ftt_on_trap_r6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    op_done |=> (!trap_req || stat_out[FTT_LSB +: FTT_W] == FTT_IEEE));
endmodule

// File: tb/fpx_status_upd_tb.sv
`timescale 1ns/1ps
module fpx_status_upd_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_done;
  logic [4:0]  op_flags;
  logic [31:0] stat_in, pc_in, npc_in;
  logic [31:0] stat_out, pc_out, npc_out;
  logic        trap_req;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  fpx_status_upd u_dut (
    .clk(clk), .rst_n(rst_n), .op_done(op_done), .op_flags(op_flags),
    .stat_in(stat_in), .pc_in(pc_in), .npc_in(npc_in),
    .stat_out(stat_out), .trap_req(trap_req), .pc_out(pc_out), .npc_out(npc_out)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scramble();
    op_flags = 5'($urandom);
    stat_in  = $urandom;
    pc_in    = $urandom;
    npc_in   = $urandom;
  endtask

  initial begin
    #4000000;
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] e_stat, e_pc, e_npc, s_stat, s_pc, s_npc;
    logic [4:0]  en, cexc;
    bit          e_trap;
    rst_n = 1'b0; op_done = 1'b0;
    scramble();
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(stat_out == 0 && !trap_req, "R1 in reset", stat_out, 0);
    chk(pc_out == 0 && npc_out == 0, "R1 pc in reset", pc_out, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(stat_out == 0 && !trap_req && pc_out == 0 && npc_out == 0, "R1 after release", stat_out, 0);

    for (int m = 0; m < 32; m++) begin
      for (int f = 0; f < 32; f++) begin
        scramble();
        op_flags = 5'(f);
        stat_in[27:23] = 5'(m);
        op_done = 1'b1;
        s_stat = stat_in; s_pc = pc_in; s_npc = npc_in;
        en = 5'(f) & 5'(m);
        e_trap = (en != 0);
        cexc = 5'(f);
        if (e_trap) begin
          cexc = 0;
          for (int b = 4; b >= 0; b--) begin
            if (en[b]) begin cexc[b] = 1'b1; break; end
          end
        end
        e_stat = s_stat;
        e_stat[4:0] = cexc;
        if (e_trap) e_stat[16:14] = 3'd1;
        else        e_stat[9:5] = s_stat[9:5] | cexc;
        e_pc  = e_trap ? s_pc  : s_npc;
        e_npc = e_trap ? s_npc : s_npc + 32'd4;
        @(negedge clk);
        op_done = 1'b0;
        chk(trap_req == e_trap, "R2 trap", 32'(trap_req), 32'(e_trap));
        if (e_trap) chk(stat_out[4:0] == cexc, "R3 single flag", 32'(stat_out[4:0]), 32'(cexc));
        else        chk(stat_out[4:0] == 5'(f), "R4 raw flags", 32'(stat_out[4:0]), 32'(f));
        chk(stat_out[9:5] == e_stat[9:5], "R5 accrued", 32'(stat_out[9:5]), 32'(e_stat[9:5]));
        chk(stat_out[16:14] == e_stat[16:14], "R6 trap type", 32'(stat_out[16:14]), 32'(e_stat[16:14]));
        chk(pc_out == e_pc && npc_out == e_npc, "R7 pc step", pc_out, e_pc);
        if (f == 0) chk(stat_out[4:0] == 0 && !trap_req && pc_out == s_npc, "R8 clean op", stat_out, e_stat);
        chk(stat_out == e_stat, "R10 whole word", stat_out, e_stat);
        scramble();
        @(negedge clk);
        chk(stat_out == e_stat && !trap_req && pc_out == e_pc && npc_out == e_npc,
            "R9 idle hold", stat_out, e_stat);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule